// File: doc/BRIEF.md
# Snake-Order Mesh Merge Sorter

This block sorts a square array of unsigned keys, KSIDE x KSIDE with KSIDE a power of two. Each key sits in its own compare-exchange cell. Two cells exchange or compare keys only when the current step pairs them. All cells are loaded in one transfer. A controller then runs a fixed schedule of steps. The result is the array in snake order: rows with an even index ascend from left to right, rows with an odd index ascend from right to left, and the last key of each row is followed by the key directly below it.

The block has two modes. In merge mode, each of the four KSIDE/2 x KSIDE/2 quadrants must already be snake-sorted, and one merge pass combines them. The pass has three parts:
- a perfect shuffle of the columns inside every row, done as plain neighbour exchanges;
- odd-even transposition inside every two-column strip, in snake order;
- odd-even transposition over the whole array, in snake order.

In full-sort mode, the same merge pass runs on blocks of side 2, then 4, and so on up to KSIDE. Any input comes out sorted.

Data moves in and out over valid/ready handshakes.
- Input side: a transfer takes place on a clock edge where in_valid and in_ready are both high. in_ready is high only while the block is idle. A source may hold in_valid high for as long as it likes, but nothing is taken while the block is busy.
- Output side: once the result is ready, out_valid stays high and out_keys stays unchanged until out_ready is seen high on a clock edge. The sink can therefore stall for any number of cycles.
- done pulses for the first cycle of each result.

Top module: `msort_mesh`

## Requirements
- R1: Key of cell (row r, column c) travels in bits [(r*KSIDE+c)*KEY_W +: KEY_W] of in_keys and out_keys; a transfer is accepted on a rising edge with in_valid and in_ready both high.
- R2: With in_mode=0 and every quadrant snake-sorted, cell (r,c) of the result holds the key of ascending rank r*KSIDE + (r even ? c : KSIDE-1-c).
- R3: With in_mode=1 any input array yields the same snake-ordered arrangement as R2.
- R4: The result is a permutation of the input keys: duplicates keep their multiplicity and an all-equal array is returned unchanged.
- R5: In merge mode out_valid first rises exactly KSIDE/2-1 + 4*KSIDE cycles after the accepting edge.
- R6: In full-sort mode out_valid first rises exactly the sum over s = 2,4,...,KSIDE of (s/2-1 + 4*s) cycles after the accepting edge.
- R7: done is high for exactly one cycle, the first cycle in which out_valid is high.
- R8: While out_valid is high and out_ready low, out_valid and out_keys hold; after the edge with both high, out_valid falls and in_ready rises.
- R9: in_ready is low from the cycle after acceptance until the result is taken; in_valid, in_mode and in_keys presented meanwhile have no effect on the result.
- R10: After reset in_ready is 1, out_valid is 0 and done is 0.
- R11: Keys compare as unsigned numbers, so 0 and 2^KEY_W-1 land at the first and last snake positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers an array |
| in_ready | output | 1 | Block is idle and takes an array |
| in_mode | input | 1 | 0 = merge four sorted quadrants, 1 = full sort |
| in_keys | input | KSIDE*KSIDE*KEY_W | Input array, cell (r,c) in slot r*KSIDE+c |
| out_valid | output | 1 | Sorted array available |
| out_ready | input | 1 | Sink takes the array |
| out_keys | output | KSIDE*KSIDE*KEY_W | Sorted array, same slot layout |
| done | output | 1 | One-cycle pulse when a result first appears |

## Verification
If the step or level counters go wrong, the clearest symptom at the ports is timing: out_valid rises a cycle or more too early or too late, and the exact latency check catches this on the very first array. If the partner selection goes wrong, keys end up on the wrong cells, or a key is duplicated where a shuffle exchange is one-sided. This shows up in out_keys as soon as that array finishes, and patterns that need long-distance movement make it most visible: reversed keys, keys already in row order, and extreme values. A handshake fault, such as taking input while busy or dropping a result during back-pressure, shows as a changed or missing result in the cycle the sink stalls or the source pushes.

// File: rtl/msort_pkg.sv
package msort_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_SHUF,
    ST_COLS,
    ST_SNAKE,
    ST_DONE
  } msort_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SHUF,
    PH_COLS,
    PH_SNAKE
  } phase_e;

  typedef enum logic [1:0] {
    OP_KEEP,
    OP_XCHG,
    OP_LOW,
    OP_HIGH
  } cell_op_e;

endpackage

// File: rtl/msort_cell.sv
module msort_cell
  import msort_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [KEY_W-1:0] load_key,
  input  logic             step_en,
  input  cell_op_e         op_i,
  input  logic [KEY_W-1:0] partner_key,
  output logic [KEY_W-1:0] key_o
);

  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] key_d;

  // Unsigned compare; a tie leaves the cell's own key in place.
  always_comb begin
    case (op_i)
      OP_XCHG: key_d = partner_key;
      OP_LOW:  key_d = (partner_key < key_q) ? partner_key : key_q;
      OP_HIGH: key_d = (partner_key > key_q) ? partner_key : key_q;
      default: key_d = key_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_q <= '0;
    else if (load_en) key_q <= load_key;
    else if (step_en) key_q <= key_d;
  end

  assign key_o = key_q;

endmodule

// File: rtl/msort_route.sv
module msort_route
  import msort_pkg::*;
#(
  parameter int KSIDE  = 4,
  parameter int CNT_W  = $clog2(2 * KSIDE),
  parameter int LVL_W  = $clog2($clog2(KSIDE) + 1),
  parameter int SLOT_W = $clog2(KSIDE * KSIDE)
) (
  input  phase_e            phase_i,
  input  logic [CNT_W-1:0]  step_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output cell_op_e          op_o   [KSIDE*KSIDE],
  output logic [SLOT_W-1:0] part_o [KSIDE*KSIDE]
);

  for (genvar gr = 0; gr < KSIDE; gr++) begin : g_row
    for (genvar gc = 0; gc < KSIDE; gc++) begin : g_col
      localparam int SLOT = gr * KSIDE + gc;

      cell_op_e op_l;
      int       pr_l;
      int       pc_l;

      always_comb begin
        int   s, h, lr, lc, br, bc, t, lo, hi;
        int   idx, len, pidx, plr, pos;
        logic low;
        s    = 1 << int'(lvl_i);
        h    = s >> 1;
        lr   = gr & (s - 1);
        lc   = gc & (s - 1);
        br   = gr - lr;
        bc   = gc - lc;
        t    = int'(step_i) + 1;
        lo   = h - t;
        hi   = h + t - 2;
        idx  = 0;
        len  = 0;
        pidx = 0;
        plr  = 0;
        pos  = 0;
        low  = 1'b0;
        op_l = OP_KEEP;
        pr_l = gr;
        pc_l = gc;

        if (phase_i == PH_SHUF) begin
          // Step t swaps t disjoint neighbour pairs centred on the block's middle.
          if (lc >= lo && lc <= hi && ((lc - lo) & 1) == 0) begin
            pc_l = gc + 1;
            op_l = OP_XCHG;
          end else if (lc - 1 >= lo && lc - 1 <= hi && ((lc - 1 - lo) & 1) == 0) begin
            pc_l = gc - 1;
            op_l = OP_XCHG;
          end
        end else if (phase_i == PH_COLS || phase_i == PH_SNAKE) begin
          if (phase_i == PH_COLS) begin
            len = 2 * s;
            idx = 2 * lr + (((lr & 1) == 0) ? (gc & 1) : 1 - (gc & 1));
          end else begin
            len = s * s;
            idx = (lr << int'(lvl_i)) + (((lr & 1) == 0) ? lc : s - 1 - lc);
          end
          if (step_i[0] == 1'b0) begin
            pidx = idx ^ 1;
            low  = ((idx & 1) == 0);
          end else if ((idx & 1) == 1) begin
            pidx = idx + 1;
            low  = 1'b1;
          end else begin
            pidx = idx - 1;
            low  = 1'b0;
          end
          if (pidx >= 0 && pidx < len) begin
            if (phase_i == PH_COLS) begin
              plr  = pidx >> 1;
              pos  = pidx & 1;
              pr_l = br + plr;
              pc_l = (gc & ~1) + (((plr & 1) == 0) ? pos : 1 - pos);
            end else begin
              plr  = pidx >> int'(lvl_i);
              pos  = pidx & (s - 1);
              pr_l = br + plr;
              pc_l = bc + (((plr & 1) == 0) ? pos : s - 1 - pos);
            end
            op_l = low ? OP_LOW : OP_HIGH;
          end
        end
      end

      assign op_o[SLOT]   = op_l;
      assign part_o[SLOT] = SLOT_W'(pr_l * KSIDE + pc_l);
    end
  end

endmodule

// File: rtl/msort_ctrl.sv
module msort_ctrl
  import msort_pkg::*;
#(
  parameter int KSIDE = 4,
  parameter int CNT_W = $clog2(2 * KSIDE),
  parameter int LVL_W = $clog2($clog2(KSIDE) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_mode,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             done,
  output logic             mode_full,
  output logic             load_en,
  output logic             step_en,
  output phase_e           phase,
  output logic [CNT_W-1:0] step,
  output logic [LVL_W-1:0] lvl
);

  localparam int LG = $clog2(KSIDE);

  function automatic int shuf_len(input int l);
    return ((1 << l) >> 1) - 1;
  endfunction

  function automatic int oets_len(input int l);
    return 2 * (1 << l);
  endfunction

  msort_state_e     st_q, st_d;
  logic [CNT_W-1:0] step_q, step_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             mode_q, mode_d;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    lvl_d  = lvl_q;
    mode_d = mode_q;
    done_d = 1'b0;
    case (st_q)
      ST_LOAD: begin
        if (in_valid) begin
          mode_d = in_mode;
          lvl_d  = in_mode ? LVL_W'(1) : LVL_W'(LG);
          step_d = '0;
          st_d   = (shuf_len(int'(lvl_d)) > 0) ? ST_SHUF : ST_COLS;
        end
      end
      ST_SHUF: begin
        if (int'(step_q) == shuf_len(int'(lvl_q)) - 1) begin
          step_d = '0;
          st_d   = ST_COLS;
        end else begin
          step_d = step_q + CNT_W'(1);
        end
      end
      ST_COLS: begin
        if (int'(step_q) == oets_len(int'(lvl_q)) - 1) begin
          step_d = '0;
          st_d   = ST_SNAKE;
        end else begin
          step_d = step_q + CNT_W'(1);
        end
      end
      ST_SNAKE: begin
        if (int'(step_q) == oets_len(int'(lvl_q)) - 1) begin
          step_d = '0;
          if (mode_q && int'(lvl_q) < LG) begin
            lvl_d = lvl_q + LVL_W'(1);
            st_d  = (shuf_len(int'(lvl_d)) > 0) ? ST_SHUF : ST_COLS;
          end else begin
            st_d   = ST_DONE;
            done_d = 1'b1;
          end
        end else begin
          step_d = step_q + CNT_W'(1);
        end
      end
      ST_DONE: begin
        if (out_ready) st_d = ST_LOAD;
      end
      default: st_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOAD;
      step_q <= '0;
      lvl_q  <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      lvl_q  <= lvl_d;
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_SHUF:  phase = PH_SHUF;
      ST_COLS:  phase = PH_COLS;
      ST_SNAKE: phase = PH_SNAKE;
      default:  phase = PH_IDLE;
    endcase
  end

  assign in_ready  = (st_q == ST_LOAD);
  assign out_valid = (st_q == ST_DONE);
  assign done      = done_q;
  assign mode_full = mode_q;
  assign load_en   = in_valid && in_ready;
  assign step_en   = (st_q == ST_SHUF) || (st_q == ST_COLS) || (st_q == ST_SNAKE);
  assign step      = step_q;
  assign lvl       = lvl_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

endmodule

// File: rtl/msort_mesh.sv
module msort_mesh
  import msort_pkg::*;
#(
  parameter int KSIDE = 4,
  parameter int KEY_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic                           in_mode,
  input  logic [KSIDE*KSIDE*KEY_W-1:0]   in_keys,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [KSIDE*KSIDE*KEY_W-1:0]   out_keys,
  output logic                           done
);

  localparam int N      = KSIDE * KSIDE;
  localparam int CNT_W  = $clog2(2 * KSIDE);
  localparam int LVL_W  = $clog2($clog2(KSIDE) + 1);
  localparam int SLOT_W = $clog2(N);

  logic             load_en, step_en, mode_full;
  phase_e           phase;
  logic [CNT_W-1:0] step;
  logic [LVL_W-1:0] lvl;

  logic [KEY_W-1:0]  key_w  [N];
  cell_op_e          op_w   [N];
  logic [SLOT_W-1:0] part_w [N];

  msort_ctrl #(.KSIDE(KSIDE), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .done      (done),
    .mode_full (mode_full),
    .load_en   (load_en),
    .step_en   (step_en),
    .phase     (phase),
    .step      (step),
    .lvl       (lvl)
  );

  msort_route #(.KSIDE(KSIDE), .CNT_W(CNT_W), .LVL_W(LVL_W), .SLOT_W(SLOT_W)) u_route (
    .phase_i (phase),
    .step_i  (step),
    .lvl_i   (lvl),
    .op_o    (op_w),
    .part_o  (part_w)
  );

  for (genvar gi = 0; gi < N; gi++) begin : g_cell
    msort_cell #(.KEY_W(KEY_W)) u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_en     (load_en),
      .load_key    (in_keys[gi*KEY_W +: KEY_W]),
      .step_en     (step_en),
      .op_i        (op_w[gi]),
      .partner_key (key_w[part_w[gi]]),
      .key_o       (key_w[gi])
    );
    assign out_keys[gi*KEY_W +: KEY_W] = key_w[gi];
  end

  function automatic logic snake_sorted(input logic [N*KEY_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < N; i++) begin
      int ra, ca, rb, cb;
      ra = (i - 1) / KSIDE;
      ca = ((ra & 1) == 0) ? (i - 1) % KSIDE : KSIDE - 1 - (i - 1) % KSIDE;
      rb = i / KSIDE;
      cb = ((rb & 1) == 0) ? i % KSIDE : KSIDE - 1 - i % KSIDE;
      if (v[(ra*KSIDE+ca)*KEY_W +: KEY_W] > v[(rb*KSIDE+cb)*KEY_W +: KEY_W]) ok = 1'b0;
    end
    return ok;
  endfunction

  // R8
  keys_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_keys));

  // R3
  full_sorted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_full) |-> snake_sorted(out_keys));

endmodule

// File: tb/test_msort_mesh.sv
module test_msort_mesh;
  localparam int  K          = 4;
  localparam int  W          = 8;
  localparam int  N          = K * K;
  localparam int  H          = K / 2;
  localparam int  LG         = $clog2(K);
  localparam int  NITEMS     = 10;
  localparam int  WDOG       = 5000;
  localparam time CLK_PERIOD = 10;

  typedef logic [N-1:0][W-1:0] keys_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_mode = 1'b0;
  logic         out_ready = 1'b0;
  logic [N*W-1:0] in_keys = '0;
  logic         in_ready, out_valid, done;
  logic [N*W-1:0] out_keys;

  msort_mesh #(.KSIDE(K), .KEY_W(W)) i_msort_mesh (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_keys(in_keys), .out_valid(out_valid),
    .out_ready(out_ready), .out_keys(out_keys), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, got = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  keys_t exp_q[$];
  int    due_q[$];
  bit    full_q[$];
  string tag_q[$];

  task automatic chk_int(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input string what, input keys_t act, input keys_t exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic keys_t sort_keys(input keys_t a);
    keys_t v = a;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (v[j] > v[j+1]) begin
          logic [W-1:0] t = v[j];
          v[j] = v[j+1];
          v[j+1] = t;
        end
    return v;
  endfunction

  function automatic keys_t snake_place(input keys_t srt);
    keys_t o;
    for (int r = 0; r < K; r++)
      for (int c = 0; c < K; c++)
        o[r*K+c] = srt[r*K + ((r % 2 == 0) ? c : K - 1 - c)];
    return o;
  endfunction

  // Each quadrant gets H*H raw keys, sorted and laid out in its own snake order.
  function automatic keys_t make_merge(input keys_t raw);
    keys_t o = '0;
    for (int q = 0; q < 4; q++) begin
      logic [W-1:0] g [H*H];
      for (int i = 0; i < H*H; i++) g[i] = raw[q*H*H + i];
      for (int i = 0; i < H*H; i++)
        for (int j = 0; j < H*H - 1 - i; j++)
          if (g[j] > g[j+1]) begin
            logic [W-1:0] t = g[j];
            g[j] = g[j+1];
            g[j+1] = t;
          end
      for (int lr = 0; lr < H; lr++)
        for (int lc = 0; lc < H; lc++)
          o[((q/2)*H + lr)*K + (q%2)*H + lc] = g[lr*H + ((lr % 2 == 0) ? lc : H - 1 - lc)];
    end
    return o;
  endfunction

  function automatic int lat_of(input bit full);
    int tot = 0;
    for (int l = (full ? 1 : LG); l <= LG; l++) begin
      int s = 1 << l;
      tot += s / 2 - 1 + 4 * s;
    end
    return tot;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Driver: offers one array, records the expectation, then pushes junk while busy.
  task automatic send(input keys_t keys, input bit full, input string tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_keys  = keys;
    in_mode  = full;
    in_valid = 1'b1;
    exp_q.push_back(snake_place(sort_keys(keys)));
    due_q.push_back(cyc + 1 + lat_of(full));
    full_q.push_back(full);
    tag_q.push_back(tag);
    @(negedge clk);
    in_keys = ~keys;
    in_mode = ~full;
    for (int i = 0; i < 3; i++) begin
      chk_int("R9", "in_ready while busy", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Monitor: pops expectations as results appear, with back-pressure on odd items.
  initial begin : monitor
    keys_t held;
    int    idx = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (out_valid) begin
        held = out_keys;
        chk_int(full_q[0] ? "R6" : "R5", "first out_valid cycle", cyc, due_q[0]);
        chk_int("R7", "done on first result cycle", done, 1);
        if (idx % 2 == 1) begin
          for (int i = 0; i < 3; i++) begin
            out_ready = 1'b0;
            @(negedge clk);
            chk_int("R8", "out_valid held under stall", out_valid, 1);
            chk_vec("R8", "out_keys held under stall", out_keys, held);
            chk_int("R7", "done low after first cycle", done, 0);
          end
        end
        out_ready = 1'b1;
        chk_vec(tag_q[0], "sorted array", out_keys, exp_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(full_q.pop_front());
        void'(tag_q.pop_front());
        @(negedge clk);
        out_ready = 1'b0;
        chk_int("R8", "out_valid after handshake", out_valid, 0);
        chk_int("R8", "in_ready after handshake", in_ready, 1);
        idx++;
        got++;
      end
    end
  end

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d results", got, NITEMS);
      summary();
      $finish;
    end
  end

  initial begin : main
    keys_t raw;
    repeat (3) @(negedge clk);
    chk_int("R10", "in_ready in reset", in_ready, 1);
    chk_int("R10", "out_valid in reset", out_valid, 0);
    chk_int("R10", "done in reset", done, 0);
    rst_n = 1'b1;

    for (int it = 0; it < NITEMS; it++) begin
      bit    full;
      string tag;
      for (int i = 0; i < N; i++) raw[i] = W'($urandom_range(0, (1 << W) - 1));
      full = (it >= 4);
      case (it)
        0: tag = "R1/R2";
        1: tag = "R2";
        2: begin
          tag = "R11";
          for (int i = 0; i < N; i++) if (i % 3 != 2) raw[i] = (i % 3 == 0) ? '0 : '1;
        end
        3: begin
          tag = "R4";
          for (int i = 0; i < N; i++) raw[i] = 8'h5A;
        end
        5: begin
          tag = "R3";
          for (int i = 0; i < N; i++) raw[i] = W'(255 - i * 7);
        end
        6: begin
          tag = "R4";
          for (int i = 0; i < N; i++) raw[i] = W'((i * 5) % 3 * 100);
        end
        7: begin
          tag = "R11";
          for (int i = 0; i < N; i++) if (i % 2 == 0) raw[i] = (i % 4 == 0) ? '1 : '0;
        end
        9: begin
          tag = "R3";
          for (int i = 0; i < N; i++) raw[i] = W'(i * 3);
        end
        default: tag = "R3";
      endcase
      send(full ? raw : make_merge(raw), full, tag);
    end

    wait (got == NITEMS);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule